// File: doc/BRIEF.md
# Tagged capability memory access unit

This unit stands between a requester and a 64-bit, word-addressed data memory. It keeps one validity tag bit for each 16-byte line and accepts five kinds of request: plain loads and stores of 1, 2, 4, 8 or 16 bytes, 128-bit capability loads and stores, and 32-bit instruction fetches. Each request carries the requester's permission bits and a bounds verdict computed upstream. The unit checks the permissions and the alignment, and reports any error as a two-bit fault code. When the access is allowed, it performs the memory access and maintains the tag of the line it touched.

A capability travels as two 64-bit words. The lower word holds the address field and goes to the line's first word. The upper word holds the metadata, already compressed, and goes to the second word. A tag becomes set only when a capability is stored from a tagged source. Any plain store into a line clears that line's tag. A capability load returns the stored tag ANDed with the load-capability permission.

The controller is a four-state machine:
- `S_IDLE` accepts a request. It goes to `S_RESP` when the request faults and to `S_LO` otherwise.
- `S_LO` issues the first memory word. When the memory answers ready, it goes to `S_HI` for a two-word access and to `S_RESP` otherwise.
- `S_HI` issues the second word. It goes to `S_RESP` on ready.
- `S_RESP` presents the response for one cycle and returns to `S_IDLE`.

Top module: `cap_mem_unit`

## Requirements
- R1: After reset every tag is zero. The tag of a byte address is the bit at index address/16.
- R2: Fault codes are 0 none, 1 permission, 2 alignment and 3 bounds. A set bounds input wins over everything, a permission fault wins over an alignment fault, and a faulted request issues no memory access, changes no tag and returns zero data with tag 0.
- R3: Operation codes are 0 plain load, 1 plain store, 2 capability load, 3 capability store and 4 fetch. Permission bits are bit0 load, bit1 store, bit2 load-capability, bit3 store-capability and bit4 execute. Each operation needs these bits:
  - plain load: load
  - plain store: store
  - capability load: load
  - capability store: store and store-capability
  - fetch: load and execute
  - operation codes 5 to 7: always a permission fault.
- R4: The size code gives a width of 2^code bytes (codes 0 to 4). A plain access must be aligned to its own width, a capability access to 16 bytes and a fetch to 4 bytes. Size codes 5 to 7 on a plain access give an alignment fault.
- R5: A capability store writes the lower data word at the line's first word and then the upper word at the second word (base + 8). The line's tag takes the source tag on the cycle the second word is written.
- R6: A capability load returns the first word on the low data output and the second word on the high data output. The returned tag is the line's tag ANDed with permission bit2; the data is returned even when bit2 is clear.
- R7: A plain store writes only the addressed bytes (little-endian, byte k of a word at bits 8k+7:8k), taking them from the low bytes of the write data; a 16-byte store writes both words. Any plain store clears the tag of its line.
- R8: A plain load returns the addressed bytes zero-extended on the low data output (a 16-byte load also fills the high output). It reports tag 0 and leaves every tag unchanged.
- R9: A fetch returns the addressed 32 bits zero-extended on the low data output.
- R10: The request-ready output is high only while the unit is idle. The response-valid output lasts exactly one cycle. A memory request holds its address, data and write enable steady until the memory answers ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_op | input | 3 | Operation code |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 3 | Plain access size code |
| req_wdata_lo | input | 64 | Write data, low word / capability address word |
| req_wdata_hi | input | 64 | Write data, high word / compressed metadata |
| req_wtag | input | 1 | Source tag of a capability store |
| req_perm | input | 5 | Requester permission bits |
| req_bounds_err | input | 1 | Upstream bounds check failed |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_fault | output | 2 | Fault code |
| rsp_rdata_lo | output | 64 | Read data, low word |
| rsp_rdata_hi | output | 64 | Read data, high word |
| rsp_tag | output | 1 | Returned tag |
| mem_valid | output | 1 | Memory request |
| mem_ready | input | 1 | Memory accepts / read data valid |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W-3 | Memory word address |
| mem_be | output | 8 | Byte enables |
| mem_wdata | output | 64 | Memory write data |
| mem_rdata | input | 64 | Memory read data, valid with ready |

## Verification
The assertions check, on every cycle, the handshake rules and the ordering of the port signals:
- a faulted request leaves the memory port idle;
- a tag write happens only while a memory write is completing;
- the lower word of a capability goes out before the upper word;
- a pending memory request stays steady;
- the response pulse lasts one cycle;
- a returned tag never accompanies a fault.

Only the bench's scenarios can show the values themselves: the bytes that reach memory, the tag that results from each mix of stores, the masking by permission bit2, and the fault chosen for each of the operation and permission combinations. The bench judges these against a byte-level model of the memory and a separate tag model, with the memory's ready signal stalling at irregular intervals.

// File: rtl/cmu_pkg.sv
package cmu_pkg;
    typedef enum logic [2:0] {
        OP_LOAD   = 3'd0,
        OP_STORE  = 3'd1,
        OP_CLOAD  = 3'd2,
        OP_CSTORE = 3'd3,
        OP_FETCH  = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_PERM   = 2'd1,
        FLT_ALIGN  = 2'd2,
        FLT_BOUNDS = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_LO,
        S_HI,
        S_RESP
    } state_e;

    localparam int PB_LOAD  = 0;
    localparam int PB_STORE = 1;
    localparam int PB_LCAP  = 2;
    localparam int PB_SCAP  = 3;
    localparam int PB_EXEC  = 4;
    localparam int PERM_W   = 5;
    localparam logic [2:0] SZ_LINE  = 3'd4;
    localparam logic [2:0] SZ_FETCH = 3'd2;
endpackage

// File: rtl/cmu_check.sv
module cmu_check
    import cmu_pkg::*;
(
    input  logic [2:0]        op,
    input  logic [3:0]        addr_lo,
    input  logic [2:0]        size,
    input  logic [PERM_W-1:0] perm,
    input  logic              bounds_err,
    output logic [1:0]        fault,
    output logic [2:0]        eff_size,
    output logic              two_words,
    output logic              is_write
);
    logic [PERM_W-1:0] need;
    logic              bad_op;
    logic              perm_ok;
    logic              align_ok;
    logic [3:0]        amask;

    always_comb begin
        need   = '0;
        bad_op = 1'b0;
        unique case (op)
            OP_LOAD:   need[PB_LOAD] = 1'b1;
            OP_STORE:  need[PB_STORE] = 1'b1;
            OP_CLOAD:  need[PB_LOAD] = 1'b1;
            OP_CSTORE: begin
                need[PB_STORE] = 1'b1;
                need[PB_SCAP]  = 1'b1;
            end
            OP_FETCH: begin
                need[PB_LOAD] = 1'b1;
                need[PB_EXEC] = 1'b1;
            end
            default: bad_op = 1'b1;
        endcase
    end

    assign perm_ok = !bad_op && ((perm & need) == need);

    always_comb begin
        unique case (op)
            OP_CLOAD, OP_CSTORE: eff_size = SZ_LINE;
            OP_FETCH:            eff_size = SZ_FETCH;
            default:             eff_size = size;
        endcase
    end

    always_comb begin
        unique case (eff_size)
            3'd0:    amask = 4'h0;
            3'd1:    amask = 4'h1;
            3'd2:    amask = 4'h3;
            3'd3:    amask = 4'h7;
            default: amask = 4'hF;
        endcase
    end

    assign align_ok  = (eff_size <= SZ_LINE) && ((addr_lo & amask) == 4'h0);
    assign two_words = (eff_size == SZ_LINE);
    assign is_write  = (op == OP_STORE) || (op == OP_CSTORE);

    always_comb begin
        if (bounds_err)    fault = FLT_BOUNDS;
        else if (!perm_ok) fault = FLT_PERM;
        else if (!align_ok) fault = FLT_ALIGN;
        else               fault = FLT_NONE;
    end

    always_comb begin
        if (bounds_err) a_bounds_first_r2: assert (fault == FLT_BOUNDS);
    end
endmodule

// File: rtl/cmu_lane.sv
module cmu_lane #(
    parameter int WORD_BYTES = 8
) (
    input  logic [2:0]              size,
    input  logic [2:0]              off,
    input  logic [8*WORD_BYTES-1:0] wdata,
    input  logic [8*WORD_BYTES-1:0] rdata,
    output logic [WORD_BYTES-1:0]   be,
    output logic [8*WORD_BYTES-1:0] wword,
    output logic [8*WORD_BYTES-1:0] rbytes
);
    logic [WORD_BYTES-1:0]   keep;
    logic [8*WORD_BYTES-1:0] shifted;

    always_comb begin
        unique case (size)
            3'd0:    keep = WORD_BYTES'(8'h01);
            3'd1:    keep = WORD_BYTES'(8'h03);
            3'd2:    keep = WORD_BYTES'(8'h0F);
            default: keep = '1;
        endcase
    end

    assign be      = keep << off;
    assign wword   = wdata << {off, 3'b000};
    assign shifted = rdata >> {off, 3'b000};

    for (genvar i = 0; i < WORD_BYTES; i++) begin : g_byte
        assign rbytes[8*i +: 8] = keep[i] ? shifted[8*i +: 8] : 8'h00;
    end
endmodule

// File: rtl/cmu_tags.sv
module cmu_tags #(
    parameter int LINES  = 64,
    localparam int LINE_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] rd_line,
    output logic              rd_tag,
    input  logic              we,
    input  logic [LINE_W-1:0] wr_line,
    input  logic              wr_val
);
    logic [LINES-1:0] tag_vec;

    always_ff @(posedge clk) begin
        if (!rst_n)  tag_vec <= '0;
        else if (we) tag_vec[wr_line] <= wr_val;
    end

    assign rd_tag = tag_vec[rd_line];

    p_one_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tag_vec ^ $past(tag_vec)) <= 1);
endmodule

// File: rtl/cap_mem_unit.sv
module cap_mem_unit
    import cmu_pkg::*;
#(
    parameter int ADDR_W = 10,
    localparam int WORD_AW = ADDR_W - 3,
    localparam int LINE_W  = ADDR_W - 4,
    localparam int LINES   = 1 << LINE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [2:0]         req_op,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [2:0]         req_size,
    input  logic [63:0]        req_wdata_lo,
    input  logic [63:0]        req_wdata_hi,
    input  logic               req_wtag,
    input  logic [4:0]         req_perm,
    input  logic               req_bounds_err,
    output logic               rsp_valid,
    output logic [1:0]         rsp_fault,
    output logic [63:0]        rsp_rdata_lo,
    output logic [63:0]        rsp_rdata_hi,
    output logic               rsp_tag,
    output logic               mem_valid,
    input  logic               mem_ready,
    output logic               mem_we,
    output logic [WORD_AW-1:0] mem_addr,
    output logic [7:0]         mem_be,
    output logic [63:0]        mem_wdata,
    input  logic [63:0]        mem_rdata
);
    state_e state, state_nx;

    logic [1:0]        chk_fault;
    logic [2:0]        chk_size;
    logic              chk_two, chk_wr;
    logic              accept;

    logic [2:0]        op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [2:0]        size_q;
    logic              two_q, wr_q, wtag_q, tag_q;
    logic [63:0]       wlo_q, whi_q, rlo_q, rhi_q;
    logic [1:0]        fault_q;

    logic [7:0]        lane_be;
    logic [63:0]       lane_wword, lane_rbytes;
    logic              tag_rd, tag_we, tag_val;
    logic              beat_done;

    cmu_check u_check (
        .op         (req_op),
        .addr_lo    (req_addr[3:0]),
        .size       (req_size),
        .perm       (req_perm),
        .bounds_err (req_bounds_err),
        .fault      (chk_fault),
        .eff_size   (chk_size),
        .two_words  (chk_two),
        .is_write   (chk_wr)
    );

    cmu_lane #(.WORD_BYTES(8)) u_lane (
        .size   (size_q),
        .off    (addr_q[2:0]),
        .wdata  (wlo_q),
        .rdata  (mem_rdata),
        .be     (lane_be),
        .wword  (lane_wword),
        .rbytes (lane_rbytes)
    );

    cmu_tags #(.LINES(LINES)) u_tags (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_line (req_addr[ADDR_W-1:4]),
        .rd_tag  (tag_rd),
        .we      (tag_we),
        .wr_line (addr_q[ADDR_W-1:4]),
        .wr_val  (tag_val)
    );

    assign accept    = req_valid && (state == S_IDLE);
    assign beat_done = mem_valid && mem_ready;

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (accept) state_nx = (chk_fault != FLT_NONE) ? S_RESP : S_LO;
            S_LO:   if (mem_ready) state_nx = two_q ? S_HI : S_RESP;
            S_HI:   if (mem_ready) state_nx = S_RESP;
            S_RESP: state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Request and response data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= '0;
            addr_q  <= '0;
            size_q  <= '0;
            two_q   <= 1'b0;
            wr_q    <= 1'b0;
            wtag_q  <= 1'b0;
            wlo_q   <= '0;
            whi_q   <= '0;
            fault_q <= FLT_NONE;
            rlo_q   <= '0;
            rhi_q   <= '0;
            tag_q   <= 1'b0;
        end else if (accept) begin
            op_q    <= req_op;
            addr_q  <= req_addr;
            size_q  <= chk_size;
            two_q   <= chk_two;
            wr_q    <= chk_wr;
            wtag_q  <= req_wtag;
            wlo_q   <= req_wdata_lo;
            whi_q   <= req_wdata_hi;
            fault_q <= chk_fault;
            rlo_q   <= '0;
            rhi_q   <= '0;
            tag_q   <= (req_op == OP_CLOAD) && (chk_fault == FLT_NONE)
                       && tag_rd && req_perm[PB_LCAP];
        end else if (beat_done && !wr_q) begin
            if (state == S_LO) rlo_q <= lane_rbytes;
            else               rhi_q <= mem_rdata;
        end
    end

    // Outputs
    always_comb begin
        req_ready    = (state == S_IDLE);
        rsp_valid    = (state == S_RESP);
        rsp_fault    = fault_q;
        rsp_rdata_lo = rlo_q;
        rsp_rdata_hi = rhi_q;
        rsp_tag      = tag_q;
        mem_valid    = (state == S_LO) || (state == S_HI);
        mem_we       = mem_valid && wr_q;
        mem_addr     = addr_q[ADDR_W-1:3] | WORD_AW'(state == S_HI);
        mem_be       = (state == S_HI) ? 8'hFF : lane_be;
        mem_wdata    = (state == S_HI) ? whi_q : lane_wword;
        tag_we       = beat_done && wr_q && ((state == S_HI) || !two_q);
        tag_val      = (op_q == OP_CSTORE) && wtag_q;
    end

    p_fault_no_mem_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && chk_fault != FLT_NONE) |=> !mem_valid);

    p_tag_we_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tag_we |-> (mem_valid && mem_ready && mem_we));

    p_lo_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && two_q) |-> (mem_addr[0] == (state == S_HI)));

    p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=>
            (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    p_tag_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_tag) |-> (rsp_fault == FLT_NONE));
endmodule

// File: tb/tb_cap_mem_unit.sv
module tb_cap_mem_unit;
    localparam int ADDR_W = 10;
    localparam int NBYTES = 1 << ADDR_W;
    localparam int NWORDS = NBYTES / 8;
    localparam int NLINES = NBYTES / 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [2:0]        req_op = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [2:0]        req_size = '0;
    logic [63:0]       req_wdata_lo = '0, req_wdata_hi = '0;
    logic              req_wtag = 1'b0;
    logic [4:0]        req_perm = '0;
    logic              req_bounds_err = 1'b0;
    logic              rsp_valid;
    logic [1:0]        rsp_fault;
    logic [63:0]       rsp_rdata_lo, rsp_rdata_hi;
    logic              rsp_tag;
    logic              mem_valid, mem_ready, mem_we;
    logic [ADDR_W-4:0] mem_addr;
    logic [7:0]        mem_be;
    logic [63:0]       mem_wdata, mem_rdata;

    logic [63:0] mem [0:NWORDS-1];
    logic [7:0]  ref_b [0:NBYTES-1];
    logic        ref_t [0:NLINES-1];
    logic [7:0]  lfsr;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    cap_mem_unit #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_size(req_size),
        .req_wdata_lo(req_wdata_lo), .req_wdata_hi(req_wdata_hi),
        .req_wtag(req_wtag), .req_perm(req_perm), .req_bounds_err(req_bounds_err),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_rdata_lo(rsp_rdata_lo), .rsp_rdata_hi(rsp_rdata_hi), .rsp_tag(rsp_tag),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    // Memory model with irregular stalls
    assign mem_ready = lfsr[0] | lfsr[2];
    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (!rst_n) begin
            lfsr <= 8'hA5;
            for (int w = 0; w < NWORDS; w++) mem[w] <= '0;
        end else begin
            lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            if (mem_valid && mem_ready && mem_we)
                for (int k = 0; k < 8; k++)
                    if (mem_be[k]) mem[mem_addr][8*k +: 8] <= mem_wdata[8*k +: 8];
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    function automatic logic [1:0] exp_fault(input logic [2:0] op, input int addr,
                                             input logic [2:0] sz, input logic [4:0] pm,
                                             input logic bd);
        logic [4:0] need;
        int es;
        if (bd) return 2'd3;
        case (op)
            3'd0: need = 5'b00001;
            3'd1: need = 5'b00010;
            3'd2: need = 5'b00001;
            3'd3: need = 5'b01010;
            3'd4: need = 5'b10001;
            default: return 2'd1;
        endcase
        if ((pm & need) != need) return 2'd1;
        es = (op == 3'd2 || op == 3'd3) ? 4 : (op == 3'd4) ? 2 : int'(sz);
        if (es > 4) return 2'd2;
        if ((addr % (1 << es)) != 0) return 2'd2;
        return 2'd0;
    endfunction

    task automatic run(input logic [2:0] op, input int addr, input logic [2:0] sz,
                       input logic [63:0] lo, input logic [63:0] hi, input logic wt,
                       input logic [4:0] pm, input logic bd, input string rq);
        logic [1:0]   ef;
        logic [63:0]  elo, ehi;
        logic         etag;
        logic [127:0] wd;
        int es, n, line;
        ef   = exp_fault(op, addr, sz, pm, bd);
        es   = (op == 3'd2 || op == 3'd3) ? 4 : (op == 3'd4) ? 2 : int'(sz);
        n    = (es <= 4) ? (1 << es) : 0;
        line = addr / 16;
        elo  = '0;
        ehi  = '0;
        etag = 1'b0;
        if (ef == 2'd0 && (op == 3'd0 || op == 3'd2 || op == 3'd4)) begin
            for (int k = 0; k < n; k++)
                if (k < 8) elo[8*k +: 8] = ref_b[addr + k];
                else       ehi[8*(k-8) +: 8] = ref_b[addr + k];
            if (op == 3'd2) etag = ref_t[line] & pm[2];
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid      = 1'b1;
        req_op         = op;
        req_addr       = addr[ADDR_W-1:0];
        req_size       = sz;
        req_wdata_lo   = lo;
        req_wdata_hi   = hi;
        req_wtag       = wt;
        req_perm       = pm;
        req_bounds_err = bd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        checks++;
        if (rsp_fault !== ef || rsp_rdata_lo !== elo || rsp_rdata_hi !== ehi || rsp_tag !== etag) begin
            errors++;
            $display("FAIL %s op=%0d addr=%0d: got fault=%0d lo=%h hi=%h tag=%b, expected fault=%0d lo=%h hi=%h tag=%b",
                     rq, op, addr, rsp_fault, rsp_rdata_lo, rsp_rdata_hi, rsp_tag,
                     ef, elo, ehi, etag);
        end
        if (ef == 2'd0 && (op == 3'd1 || op == 3'd3)) begin
            wd = {hi, lo};
            for (int k = 0; k < n; k++) ref_b[addr + k] = wd[8*k +: 8];
            ref_t[line] = (op == 3'd3) ? wt : 1'b0;
        end
    endtask

    initial begin
        for (int i = 0; i < NBYTES; i++) ref_b[i] = 8'h00;
        for (int i = 0; i < NLINES; i++) ref_t[i] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 R1: reset state
        checks++;
        if (req_ready !== 1'b1 || rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R10 reset: ready=%b valid=%b, expected 1 0", req_ready, rsp_valid);
        end

        // R1: all tags start at zero
        for (int l = 0; l < NLINES; l++)
            run(3'd2, l * 16, 3'd0, 0, 0, 0, 5'h1F, 0, "R1");

        // R5 R6: capability stores to every line, mixed source tags
        for (int l = 0; l < NLINES; l++)
            run(3'd3, l * 16, 3'd0, {32'hCAFE0000 + l, 32'(l)}, {32'h5EED0000, 32'(~l)},
                (l % 3) != 0, 5'h1F, 0, "R5");
        for (int l = 0; l < NLINES; l++)
            run(3'd2, l * 16, 3'd0, 0, 0, 0, ((l % 2) == 0) ? 5'h1F : 5'h1B, 0, "R6");

        // R7: plain stores of every size clear the tag and merge bytes
        for (int l = 1; l < 21; l++) begin
            int s = l % 5;
            int o = ((l * 3) << s) & 15;
            if (s == 4) o = 0;
            run(3'd1, l * 16 + o, 3'(s), 64'h1122334455667788 ^ 64'(l), 64'h99AABBCCDDEEFF00,
                0, 5'h02, 0, "R7");
            run(3'd2, l * 16, 3'd0, 0, 0, 0, 5'h1F, 0, "R7");
        end

        // R8: plain loads of all sizes and aligned offsets; tag of line 22 left intact
        for (int s = 0; s < 5; s++)
            for (int o = 0; o < 16; o += (1 << s))
                run(3'd0, 22 * 16 + o, 3'(s), 0, 0, 0, 5'h01, 0, "R8");
        run(3'd2, 22 * 16, 3'd0, 0, 0, 0, 5'h1F, 0, "R8");

        // R4: misaligned capability and plain accesses, bad size codes
        for (int o = 1; o < 16; o++) begin
            run(3'd3, 40 * 16 + o, 3'd0, 64'hDEAD, 64'hBEEF, 1, 5'h1F, 0, "R4");
            run(3'd2, 40 * 16 + o, 3'd0, 0, 0, 0, 5'h1F, 0, "R4");
        end
        run(3'd0, 30 * 16 + 2, 3'd2, 0, 0, 0, 5'h01, 0, "R4");
        run(3'd1, 30 * 16 + 4, 3'd3, 64'h77, 0, 0, 5'h02, 0, "R4");
        for (int s = 5; s < 8; s++)
            run(3'd0, 0, 3'(s), 0, 0, 0, 5'h01, 0, "R4");
        run(3'd2, 40 * 16, 3'd0, 0, 0, 0, 5'h1F, 0, "R4");

        // R3: every operation code against every permission set
        for (int op = 0; op < 8; op++)
            for (int pm = 0; pm < 32; pm++)
                run(3'(op), 50 * 16, 3'd3, 64'(op * 256 + pm), 64'(pm), 1, 5'(pm), 0, "R3");

        // R2: bounds beats permission and alignment; faults write nothing
        run(3'd3, 51 * 16 + 1, 3'd0, 64'hFFFF, 64'hFFFF, 1, 5'h00, 1, "R2");
        run(3'd1, 51 * 16, 3'd3, 64'hFFFF, 0, 0, 5'h1F, 1, "R2");
        run(3'd2, 51 * 16 + 3, 3'd0, 0, 0, 0, 5'h00, 0, "R2");
        run(3'd2, 51 * 16, 3'd0, 0, 0, 0, 5'h1F, 0, "R2");

        // R9: fetches at every word-aligned slot of two lines
        for (int k = 0; k < 8; k++)
            run(3'd4, 10 * 16 + 4 * k, 3'd0, 0, 0, 0, 5'h11, 0, "R9");

        // R10: response lasts a single cycle
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R10 pulse: valid=%b, expected 0", rsp_valid);
        end

        // R2 R7: memory image matches the model, so faults wrote nothing
        for (int w = 0; w < NWORDS; w++) begin
            logic [63:0] ew;
            for (int k = 0; k < 8; k++) ew[8*k +: 8] = ref_b[w * 8 + k];
            checks++;
            if (mem[w] !== ew) begin
                errors++;
                $display("FAIL R2 memory word %0d: got %h, expected %h", w, mem[w], ew);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule